// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss by reading a two-level page table from memory. When a miss arrives, it captures the 32-bit linear address and the access type, then reads the directory entry selected by the top ten address bits from the table whose base is held in a base register. The directory entry can end the walk by mapping a 4 MB page. It can also point to a second-level table, and the walker then reads the entry selected by the next ten bits.

Each walk ends in one of two ways. It may end with a one-cycle completion pulse that carries the physical address, a large-page flag and the effective writable flag, ready to refill a TLB. It may instead end with a one-cycle fault pulse and a reason code. Memory is reached through a single read port with a request/response handshake. The request is held until it is accepted, and the response may arrive any number of cycles later. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to `{dir_base[31:12], vaddr[31:22], 2'b00}`. Each entry is 4 bytes, so the index is scaled by four.
- R2: When the directory entry is valid and bit 7 is clear, the second read goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R3: An entry with bit 0 (valid) clear, at either level, ends the walk with `fault_code` 2'b01, and no further read is issued.
- R4: A valid directory entry with bit 7 set maps a 4 MB page after one read. The result is `{entry[31:22], vaddr[21:0]}` with `done_large` = 1.
- R5: A valid second-level entry maps a 4 KB page. The result is `{entry[31:12], vaddr[11:0]}` with `done_large` = 0. Bit 7 of a second-level entry has no effect.
- R6: `done_writable` equals bit 1 of the directory entry for a 4 MB page. For a 4 KB page it equals bit 1 of the directory entry AND bit 1 of the second-level entry.
- R7: A write miss that resolves to a page that is not writable (per R6) ends with `fault_code` 2'b10. A read miss never takes this fault.
- R8: `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. At most one read is outstanding. The walker waits for `mem_rsp_valid` for any number of cycles.
- R9: `busy` rises in the cycle after a miss is accepted in idle and stays high up to and including the done or fault cycle. `miss_valid` is ignored while `busy` is high.
- R10: `done` and `fault` are single-cycle pulses and never high together. The result fields are valid while `done` is high, and `fault_code` is valid while `fault` is high.
- R11: After reset, `busy`, `done`, `fault` and `mem_req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Directory base; bits 31:12 used |
| miss_valid | input | 1 | Start a walk (taken only when idle) |
| miss_vaddr | input | 32 | Linear address to translate |
| miss_is_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Entry address to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | Translation complete pulse |
| done_paddr | output | 32 | Physical address |
| done_large | output | 1 | 1 = 4 MB page, 0 = 4 KB page |
| done_writable | output | 1 | Effective write permission |
| fault | output | 1 | Walk fault pulse |
| fault_code | output | 2 | 01 = entry not valid, 10 = write to read-only |

## Verification
The bench sweeps all 1024 directory indices, each with a read miss and a write miss. The memory model builds the directory so that the four index classes cover all outcomes: an invalid entry, a large page, and a pointer to a second table. The second-level entries vary their valid, writable and size bits with the inner index. This separates one-read walks from two-read walks, and separates not-present faults at each level from write-protection faults. Handshake latencies on both the request and response sides vary across the sweep. Some walks raise spurious misses while waiting, to show that they leave the translation unchanged. Directed walks at the all-zero and all-one addresses check the edges of the field extraction.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W    = 32;
  localparam int IDX_W     = 10;
  localparam int OFF_W     = 12;
  localparam int ENT_LG    = 2;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int PFN_W     = ADDR_W - OFF_W;
  localparam int BFN_W     = ADDR_W - BIG_OFF_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PFN_W-1:0]  pfn_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_TBL_REQ, S_TBL_WAIT, S_DONE, S_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_WPROT  = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_LEAF    = 2'd1,
    ACT_FAULT   = 2'd2
  } action_e;

  typedef struct packed {
    action_e act;
    fault_e  code;
    logic    writable;
    logic    big;
    pfn_t    frame;
  } verdict_t;

  function automatic idx_t outer_index(input addr_t va);
    return va[ADDR_W-1 -: IDX_W];
  endfunction

  function automatic idx_t inner_index(input addr_t va);
    return va[BIG_OFF_W-1 -: IDX_W];
  endfunction

  function automatic addr_t slot_addr(input pfn_t base, input idx_t idx);
    addr_t a;
    a = {base, {OFF_W{1'b0}}};
    a = a + ({{(ADDR_W-IDX_W){1'b0}}, idx} << ENT_LG);
    return a;
  endfunction

  function automatic addr_t join_small(input pfn_t pfn, input addr_t va);
    return {pfn, va[OFF_W-1:0]};
  endfunction

  function automatic addr_t join_big(input pfn_t pfn, input addr_t va);
    return {pfn[PFN_W-1 -: BFN_W], va[BIG_OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_req_addr.sv
module ptw_req_addr
  import ptw_pkg::*;
(
  input  addr_t dir_base,
  input  addr_t va,
  input  pfn_t  tbl_base,
  input  logic  use_tbl,
  output addr_t req_addr
);
  pfn_t  dir_pfn;
  addr_t dir_slot;
  addr_t tbl_slot;

  assign dir_pfn  = dir_base[ADDR_W-1:OFF_W];
  assign dir_slot = slot_addr(dir_pfn, outer_index(va));
  assign tbl_slot = slot_addr(tbl_base, inner_index(va));
  assign req_addr = use_tbl ? tbl_slot : dir_slot;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int VALID_BIT = 0,
  parameter int WRITE_BIT = 1,
  parameter int SIZE_BIT  = 7
) (
  input  addr_t    entry,
  input  logic     is_dir,
  input  logic     is_write,
  input  logic     upper_writable,
  output verdict_t verdict
);
  logic present;
  logic maps_big;
  logic w_eff;

  assign present  = entry[VALID_BIT];
  assign maps_big = is_dir & entry[SIZE_BIT];
  assign w_eff    = entry[WRITE_BIT] & (is_dir | upper_writable);

  always_comb begin
    verdict          = '0;
    verdict.frame    = entry[ADDR_W-1:OFF_W];
    verdict.big      = maps_big;
    verdict.writable = w_eff;
    if (!present) begin
      verdict.act  = ACT_FAULT;
      verdict.code = FLT_ABSENT;
    end else if (is_dir && !maps_big) begin
      verdict.act  = ACT_DESCEND;
      verdict.code = FLT_NONE;
    end else if (is_write && !w_eff) begin
      verdict.act  = ACT_FAULT;
      verdict.code = FLT_WPROT;
    end else begin
      verdict.act  = ACT_LEAF;
      verdict.code = FLT_NONE;
    end
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_valid,
  input  logic        req_ready,
  input  logic        rsp_valid,
  input  action_e     act,
  output walk_state_e state,
  output logic        walk_accept,
  output logic        rsp_take
);
  walk_state_e nxt;

  assign walk_accept = (state == S_IDLE) & miss_valid;
  assign rsp_take    = ((state == S_DIR_WAIT) | (state == S_TBL_WAIT)) & rsp_valid;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:     if (miss_valid) nxt = S_DIR_REQ;
      S_DIR_REQ:  if (req_ready) nxt = S_DIR_WAIT;
      S_DIR_WAIT: if (rsp_valid) begin
                    case (act)
                      ACT_DESCEND: nxt = S_TBL_REQ;
                      ACT_LEAF:    nxt = S_DONE;
                      default:     nxt = S_FAULT;
                    endcase
                  end
      S_TBL_REQ:  if (req_ready) nxt = S_TBL_WAIT;
      S_TBL_WAIT: if (rsp_valid) nxt = (act == ACT_LEAF) ? S_DONE : S_FAULT;
      S_DONE:     nxt = S_IDLE;
      S_FAULT:    nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VALID_BIT = 0,
  parameter int WRITE_BIT = 1,
  parameter int SIZE_BIT  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dir_base,
  input  logic        miss_valid,
  input  logic [31:0] miss_vaddr,
  input  logic        miss_is_write,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        done,
  output logic [31:0] done_paddr,
  output logic        done_large,
  output logic        done_writable,
  output logic        fault,
  output logic [1:0]  fault_code
);
  walk_state_e state;
  logic        walk_accept;
  logic        rsp_take;
  verdict_t    verdict;

  addr_t  va_q;
  logic   wr_q;
  pfn_t   tbl_base_q;
  logic   dir_w_q;
  addr_t  paddr_q;
  logic   big_q;
  logic   w_q;
  fault_e code_q;

  logic at_dir;
  assign at_dir = (state == S_DIR_WAIT);

  ptw_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .req_ready   (mem_req_ready),
    .rsp_valid   (mem_rsp_valid),
    .act         (verdict.act),
    .state       (state),
    .walk_accept (walk_accept),
    .rsp_take    (rsp_take)
  );

  ptw_req_addr u_addr (
    .dir_base (dir_base),
    .va       (va_q),
    .tbl_base (tbl_base_q),
    .use_tbl  (state == S_TBL_REQ),
    .req_addr (mem_req_addr)
  );

  ptw_entry_decode #(
    .VALID_BIT (VALID_BIT),
    .WRITE_BIT (WRITE_BIT),
    .SIZE_BIT  (SIZE_BIT)
  ) u_dec (
    .entry          (mem_rsp_data),
    .is_dir         (at_dir),
    .is_write       (wr_q),
    .upper_writable (dir_w_q),
    .verdict        (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q       <= '0;
      wr_q       <= 1'b0;
      tbl_base_q <= '0;
      dir_w_q    <= 1'b0;
      paddr_q    <= '0;
      big_q      <= 1'b0;
      w_q        <= 1'b0;
      code_q     <= FLT_NONE;
    end else begin
      if (walk_accept) begin
        va_q <= miss_vaddr;
        wr_q <= miss_is_write;
      end
      if (rsp_take) begin
        case (verdict.act)
          ACT_DESCEND: begin
            tbl_base_q <= verdict.frame;
            dir_w_q    <= verdict.writable;
          end
          ACT_LEAF: begin
            paddr_q <= verdict.big ? join_big(verdict.frame, va_q)
                                   : join_small(verdict.frame, va_q);
            big_q   <= verdict.big;
            w_q     <= verdict.writable;
            code_q  <= FLT_NONE;
          end
          default: code_q <= verdict.code;
        endcase
      end
    end
  end

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_DIR_REQ) | (state == S_TBL_REQ);
  assign done          = (state == S_DONE);
  assign fault         = (state == S_FAULT);
  assign done_paddr    = paddr_q;
  assign done_large    = big_q;
  assign done_writable = w_q;
  assign fault_code    = code_q;
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_valid,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code,
  input logic        walk_accept,
  input logic        rsp_take
);
  // R8: request held with a stable address until accepted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: no request outside a walk
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R9: an accepted miss makes the walker busy next cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> busy);

  // R9: a start is only taken while idle
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |-> (!busy && miss_valid));

  // R9: completion is within the busy window, and busy drops after it
  a_r9_end_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);
  a_r9_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy);

  // R10: pulses are single-cycle and exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  // R3 / R7: a fault carries exactly one reason
  a_r3_fault_reason: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($countones(fault_code) == 1));

  // R8: a response is consumed only while no request is pending
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code),
  .walk_accept   (walk_accept),
  .rsp_take      (rsp_take)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0010_0000;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_is_write = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] done_paddr;
  logic        done_large;
  logic        done_writable;
  logic        fault;
  logic [1:0]  fault_code;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [31:0] DIR_BASE = 32'h0010_0000;
  localparam logic [31:0] TBL_BASE = 32'h4000_0000;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_is_write(miss_is_write),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_paddr(done_paddr), .done_large(done_large),
    .done_writable(done_writable), .fault(fault), .fault_code(fault_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Directory classes by index mod 4: 0 invalid, 1 large page, 2/3 table pointer
  function automatic logic [31:0] dir_word(input int i);
    logic [31:0] w;
    logic [31:0] r;
    w = 32'((i / 4) % 2);
    case (i % 4)
      0: r = 32'(i) * 32'd4096 + 32'd2;
      1: r = 32'((i ^ 341) % 1024) * 32'd4194304 + 32'd128 + w * 32'd2 + 32'd1;
      default: r = TBL_BASE + 32'(i) * 32'd4096 + w * 32'd2 + 32'd1;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] pt_word(input int i, input int j);
    logic [31:0] v, w, ps, fr;
    v  = ((j % 5) != 0) ? 32'd1 : 32'd0;
    w  = 32'((j / 2) % 2);
    ps = ((j % 7) == 0) ? 32'd1 : 32'd0;
    fr = (32'(i) * 32'd1024 + 32'(j)) ^ 32'h000A_5A5A;
    fr = fr % 32'd1048576;
    return fr * 32'd4096 + ps * 32'd128 + w * 32'd2 + v;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] t;
    if (a >= DIR_BASE && a < DIR_BASE + 32'd4096)
      return dir_word(int'((a - DIR_BASE) / 32'd4));
    if (a >= TBL_BASE && a < TBL_BASE + 32'd4194304) begin
      t = a - TBL_BASE;
      return pt_word(int'(t / 32'd4096), int'((t % 32'd4096) / 32'd4));
    end
    return 32'hDEAD_0000;
  endfunction

  task automatic run_walk(input logic [31:0] va, input bit wr, input int rl,
                          input int sl, input bit noise);
    int i, j, nreq, cyc, cnt, phase;
    bit fin, got_done, got_fault, busy_bad, kind_fault;
    logic [31:0] d, e, exp_pa, exp_a0, exp_a1, cur, seen0, seen1;
    logic [1:0] exp_code;
    logic exp_big, exp_w;
    int exp_nreq;

    i = int'(va / 32'd4194304);
    j = int'((va / 32'd4096) % 32'd1024);
    d = dir_word(i);
    exp_a0 = DIR_BASE + 32'(i) * 32'd4;
    exp_a1 = '0; exp_pa = '0; exp_big = 0; exp_w = 0; exp_code = 2'b00;
    kind_fault = 0; exp_nreq = 1;
    if (d[0] == 1'b0) begin
      kind_fault = 1; exp_code = 2'b01;
    end else if (d[7]) begin
      exp_w = d[1];
      if (wr && !exp_w) begin kind_fault = 1; exp_code = 2'b10; end
      else begin
        exp_big = 1;
        exp_pa = (d / 32'd4194304) * 32'd4194304 + va % 32'd4194304;
      end
    end else begin
      exp_nreq = 2;
      exp_a1 = (d / 32'd4096) * 32'd4096 + 32'(j) * 32'd4;
      e = pt_word(i, j);
      exp_w = d[1] & e[1];
      if (e[0] == 1'b0) begin kind_fault = 1; exp_code = 2'b01; end
      else if (wr && !exp_w) begin kind_fault = 1; exp_code = 2'b10; end
      else exp_pa = (e / 32'd4096) * 32'd4096 + va % 32'd4096;
    end

    miss_vaddr = va; miss_is_write = wr; miss_valid = 1'b1;
    fin = 0; got_done = 0; got_fault = 0; busy_bad = 0;
    nreq = 0; cyc = 0; cnt = 0; phase = 0; seen0 = '0; seen1 = '0; cur = '0;
    while (!fin && cyc < 80) begin
      @(negedge clk);
      cyc++;
      miss_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      if (!busy) busy_bad = 1;
      if (done || fault) begin
        got_done = done; got_fault = fault; fin = 1;
        if (got_done) begin
          check(done_paddr == exp_pa, "R4/R5", "paddr", done_paddr, exp_pa);
          check(done_large == exp_big, "R4/R5", "large flag", 32'(done_large), 32'(exp_big));
          check(done_writable == exp_w, "R6", "writable", 32'(done_writable), 32'(exp_w));
        end else begin
          check(fault_code == exp_code, "R3/R7", "fault code", 32'(fault_code), 32'(exp_code));
        end
      end else if (phase == 0 && mem_req_valid) begin
        if (cnt >= rl) begin
          mem_req_ready = 1'b1; cur = mem_req_addr; phase = 1; cnt = 0;
          if (nreq == 0) seen0 = cur; else seen1 = cur;
          nreq++;
        end else cnt++;
      end else if (phase == 1) begin
        if (cnt >= sl) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(cur); phase = 0; cnt = 0;
        end else begin
          cnt++;
          if (noise) begin
            miss_valid = 1'b1; miss_vaddr = ~va; miss_is_write = ~wr;
          end
        end
      end
    end
    miss_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    check(fin, "R8", "walk finished", 32'(fin), 32'd1);
    check(got_fault == kind_fault, "R3/R4/R5/R7", "fault vs done", 32'(got_fault), 32'(kind_fault));
    check(seen0 == exp_a0, "R1", "directory read address", seen0, exp_a0);
    check(nreq == exp_nreq, "R3/R4", "read count", 32'(nreq), 32'(exp_nreq));
    if (exp_nreq == 2)
      check(seen1 == exp_a1, "R2", "table read address", seen1, exp_a1);
    check(!busy_bad, "R9", "busy during walk", 32'(busy_bad), 32'd0);
    @(negedge clk);
    check(!busy && !done && !fault, "R9/R10", "idle after pulse",
          {29'd0, busy, done, fault}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL R8 watchdog expired: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy, "R11", "busy in reset", 32'(busy), 32'd0);
    check(!done, "R11", "done in reset", 32'(done), 32'd0);
    check(!fault, "R11", "fault in reset", 32'(fault), 32'd0);
    check(!mem_req_valid, "R11", "req in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req_valid, "R11", "idle after reset",
          {30'd0, busy, mem_req_valid}, 32'd0);
    // R1..R10 sweep over every directory index, read and write
    for (int i = 0; i < 1024; i++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] va;
        int jj;
        jj = (i * 37 + w * 11) % 1024;
        va = 32'(i) * 32'd4194304 + 32'(jj) * 32'd4096 + 32'((i * 97) % 4096);
        run_walk(va, w[0], (i + w) % 3, (i / 3) % 4, (i % 8) == 5);
      end
    end
    // field edges
    run_walk(32'hFFFF_FFFF, 1'b0, 0, 0, 1'b0);
    run_walk(32'hFFFF_FFFF, 1'b1, 2, 3, 1'b1);
    run_walk(32'h0000_0000, 1'b0, 1, 1, 1'b0);
    run_walk(32'h0040_0000, 1'b1, 0, 2, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule